// File: doc/BRIEF.md
# Oversampled Asynchronous Byte Receiver

This block receives 10-bit asynchronous serial frames on a single line. Each frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. The line is sampled on a 16x baud tick enable. A falling edge found while the receiver is idle and enabled starts a frame and realigns the slice counter. Each bit is then decided by a two-of-three vote of the samples taken at slices 8, 9 and 10. If the start bit votes high, the receiver treats it as a glitch and goes back to searching for an edge.

At the end of a frame, the assembled byte goes to a holding register and the stop bit goes to a separate flag. A ready flag is set at the same time. This transfer happens only when the ready flag is clear and the multiprocessor filter allows it: either the filter is off, or the stop bit is high. A frame that fails either condition is dropped, and the holding registers keep their old values. The ready flag stays set until the consumer pulses a clear input.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, `rx_byte` is 0x00, `rx_ninth` is 0 and `rx_ready` is 0.
- R2: While `rx_en` is low, the receiver starts no frame: a full frame on `rxd` leaves `rx_byte`, `rx_ninth` and `rx_ready` unchanged.
- R3: A valid frame with the filter off loads `rx_byte` with the data bits, the first bit received going to bit 0. It loads `rx_ninth` with the stop-bit value and sets `rx_ready`. Slices advance only on cycles with `tick16` high.
- R4: Each bit takes the majority of the line samples at slices 8, 9 and 10 after the start edge, where the edge is slice 0. A single disturbed sample in that window does not change the bit. Two disturbed samples in that window do change it. Disturbances outside the window have no effect.
- R5: A start bit that votes high aborts the frame without any transfer. The next proper frame is received normally.
- R6: While `rx_ready` is 1, a completed frame does not change `rx_byte` or `rx_ninth`, and `rx_ready` stays 1.
- R7: With `mp_filter` high, a frame whose stop bit is 0 is dropped and leaves all outputs unchanged, while a frame with stop bit 1 is transferred. With `mp_filter` low, a frame with stop bit 0 is transferred and `rx_ninth` becomes 0.
- R8: `rx_ready` holds until `ready_clr` is pulsed, and that pulse clears it. When `ready_clr` is high in the cycle a transfer happens, the byte is stored but `rx_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at 16 times the baud rate |
| rxd | input | 1 | Serial line, high when idle |
| rx_en | input | 1 | Allows new frames to start |
| mp_filter | input | 1 | When high, only frames with stop bit 1 are transferred |
| ready_clr | input | 1 | Clears the ready flag |
| rx_byte | output | 8 | Last transferred data byte |
| rx_ninth | output | 1 | Stop bit of the last transferred frame |
| rx_ready | output | 1 | Set on transfer, held until cleared |

## Verification
The bench disturbs single samples and pairs of samples inside the voting window, and also disturbs samples outside it. A receiver that uses only one sample, or that votes at the wrong slices, would then store a byte with one bit wrong. A short low pulse tests the start check: a design that skips that check would shift in garbage and raise the ready flag. Other frames arrive while the flag is set, while the filter is on with a low stop bit, and while receive is disabled. A design that overwrites on any of these would show a new byte. Holding the clear input high during a transfer checks clear priority: a design that got it backwards would leave the flag raised.

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int DBITS = 8,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             rxd,
  input  logic             rx_en,
  input  logic             mp_filter,
  input  logic             ready_clr,
  output logic [DBITS-1:0] rx_byte,
  output logic             rx_ninth,
  output logic             rx_ready
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DBITS + 2);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] SA   = CW'(OSR / 2);
  localparam logic [CW-1:0] SB   = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] SC   = CW'(OSR / 2 + 2);
  localparam logic [BW-1:0] STOPI = BW'(DBITS + 1);

  logic [1:0]       sync;
  logic             rx, rx_prev, busy;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bidx;
  logic [1:0]       smp;
  logic [DBITS-1:0] shreg;
  logic             vote, decide, load;

  assign rx     = sync[1];
  assign vote   = (smp[1] & smp[0]) | (smp[1] & rx) | (smp[0] & rx);
  assign decide = tick16 && busy && cnt == SC;
  assign load   = decide && bidx == STOPI && !rx_ready && (!mp_filter || vote);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      rx_prev <= 1'b1;
      busy    <= 1'b0;
      cnt     <= '0;
      bidx    <= '0;
      smp     <= '0;
      shreg   <= '0;
    end else begin
      sync <= {sync[0], rxd};
      if (tick16) begin
        rx_prev <= rx;
        if (!busy) begin
          if (rx_en && rx_prev && !rx) begin
            busy <= 1'b1;
            cnt  <= CW'(1);
            bidx <= '0;
          end
        end else begin
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
          if (cnt == LAST) bidx <= bidx + 1'b1;
          if (cnt == SA || cnt == SB) smp <= {smp[0], rx};
          if (cnt == SC) begin
            if (bidx == '0) begin
              if (vote) busy <= 1'b0;
            end else if (bidx == STOPI) begin
              busy <= 1'b0;
            end else begin
              shreg <= {vote, shreg[DBITS-1:1]};
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte  <= '0;
      rx_ninth <= 1'b0;
      rx_ready <= 1'b0;
    end else begin
      if (load) begin
        rx_byte  <= shreg;
        rx_ninth <= vote;
      end
      if (ready_clr)  rx_ready <= 1'b0;
      else if (load)  rx_ready <= 1'b1;
    end
  end

  p_idle_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rx_en) |=> !busy);
  p_ready_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(tick16));
  p_hold_regs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> ($stable(rx_byte) && $stable(rx_ninth)));
  p_filter_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_ready) && $past(mp_filter)) |-> rx_ninth);
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_clr |=> !rx_ready);
  p_ready_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !ready_clr) |=> rx_ready);
endmodule

// File: tb/uart_frame_rx_test.sv
`timescale 1ns/1ps
module uart_frame_rx_test;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic rx_en = 1'b1, mp_filter = 1'b0, ready_clr = 1'b0;
  logic [7:0] rx_byte;
  logic rx_ninth, rx_ready;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] tdiv = '0;
  logic [7:0] e_byte = 8'h00;
  logic e_ninth = 1'b0;

  uart_frame_rx uut (.clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .rx_en(rx_en), .mp_filter(mp_filter), .ready_clr(ready_clr),
    .rx_byte(rx_byte), .rx_ninth(rx_ninth), .rx_ready(rx_ready));

  always #2 clk = ~clk;
  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  // {mp_filter, stop, data}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 1'b1, 8'hA5}, {1'b0, 1'b1, 8'h01}, {1'b0, 1'b0, 8'h80},
    {1'b1, 1'b1, 8'h3C}, {1'b1, 1'b0, 8'hFF}, {1'b0, 1'b1, 8'h00},
    {1'b1, 1'b0, 8'h12}, {1'b0, 1'b1, 8'hFF}};

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic slot(logic v);
    @(posedge clk);
    while (!tick16) @(posedge clk);
    #1 rxd = v;
  endtask

  task automatic send(logic [7:0] d, logic stp, int gb, logic [15:0] gm);
    logic [9:0] bits;
    bits = {stp, d, 1'b0};
    for (int b = 0; b < 10; b++)
      for (int s = 0; s < 16; s++)
        slot(bits[b] ^ (b == gb && gm[s]));
    for (int s = 0; s < 16; s++) slot(1'b1);
    @(negedge clk);
  endtask

  task automatic clear_ready();
    @(posedge clk); #1 ready_clr = 1'b1;
    @(posedge clk); #1 ready_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_all(string req, logic exp_ready);
    check(req, rx_byte, e_byte);
    check(req, {7'd0, rx_ninth}, {7'd0, e_ninth});
    check(req, {7'd0, rx_ready}, {7'd0, exp_ready});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset", 1'b0);

    // table walk: R3 and R7
    for (int i = 0; i < 8; i++) begin
      logic ld;
      clear_ready();
      check("R8 clear", {7'd0, rx_ready}, 8'd0);
      mp_filter = VEC[i][9];
      send(VEC[i][7:0], VEC[i][8], -1, 16'h0);
      ld = !VEC[i][9] || VEC[i][8];
      if (ld) begin e_byte = VEC[i][7:0]; e_ninth = VEC[i][8]; end
      check_all(ld ? "R3 R7 load" : "R7 dropped", ld);
    end
    mp_filter = 1'b0;

    // R6: ready set blocks transfer
    clear_ready();
    send(8'hC3, 1'b1, -1, 16'h0);
    e_byte = 8'hC3; e_ninth = 1'b1;
    check_all("R3 load", 1'b1);
    send(8'h2D, 1'b1, -1, 16'h0);
    check_all("R6 blocked", 1'b1);
    repeat (20) @(negedge clk);
    check("R8 holds", {7'd0, rx_ready}, 8'd1);

    // R2: receive disabled
    clear_ready();
    rx_en = 1'b0;
    send(8'h77, 1'b1, -1, 16'h0);
    check_all("R2 disabled", 1'b0);
    rx_en = 1'b1;

    // R5: false start then proper frame
    for (int s = 0; s < 4; s++) slot(1'b0);
    for (int s = 0; s < 28; s++) slot(1'b1);
    @(negedge clk);
    check_all("R5 false start", 1'b0);
    send(8'h96, 1'b1, -1, 16'h0);
    e_byte = 8'h96; e_ninth = 1'b1;
    check_all("R5 after abort", 1'b1);

    // R4: voting
    clear_ready();
    send(8'h5A, 1'b1, 1, 16'h0200);
    e_byte = 8'h5A;
    check_all("R4 single glitch", 1'b1);
    clear_ready();
    send(8'h5A, 1'b1, 1, 16'h0300);
    e_byte = 8'h5B;
    check_all("R4 double glitch", 1'b1);
    clear_ready();
    send(8'h5A, 1'b1, 4, 16'hF8FF);
    e_byte = 8'h5A;
    check_all("R4 outside window", 1'b1);

    // R8: clear held during transfer wins
    clear_ready();
    @(posedge clk); #1 ready_clr = 1'b1;
    send(8'hE7, 1'b1, -1, 16'h0);
    #1 ready_clr = 1'b0;
    @(negedge clk);
    e_byte = 8'hE7;
    check_all("R8 clear wins", 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule